// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that lets a host read and write a small bank of byte-wide configuration registers, such as per-output enable bits. It runs on a fast system clock and oversamples the serial clock and data lines, so both lines are treated as ordinary inputs. The data line is open-drain. It is modelled as an input that reads the resolved line and an output-enable that pulls the line low when asserted. The whole register bank is presented as a flat parallel output, and register `i` sits in bits `[8*i+7:8*i]`.

A host frame opens with a start condition and then an address byte. An address byte of 0xDC begins a write and 0xDD begins a read. The command byte that follows the write address chooses the access mode. With bit 7 set, the access is indexed and covers one byte, and bits 6:0 give the register index. With bit 7 clear, the access is a block access that runs upward from register 0. A block write sends a byte count ahead of the data. A block read returns the count ahead of the data. A read is made as a write address and command, then a repeated start, then the read address.

The state machine has twelve states. `S_IDLE` waits for a start. `S_ADDR`, `S_CMD`, `S_CNT` and `S_WDATA` each shift in one byte. Each has a matching acknowledge state (`S_ADDR_ACK`, `S_CMD_ACK`, `S_CNT_ACK`, `S_WDATA_ACK`), which drives or withholds the ninth-clock acknowledge. `S_TX` shifts a byte out, and `S_HOST_ACK` samples the host's acknowledge. `S_WAIT` ignores the bus until the next start or stop.

The transitions are as follows:
- A start moves any state to `S_ADDR`, and a stop moves any state to `S_IDLE`.
- Each receive state moves to its acknowledge state on the eighth rising clock.
- An acknowledge state exits on the ninth falling clock. It goes to `S_WAIT` when it did not acknowledge.
- When it did acknowledge, the exit depends on the state:
  - `S_ADDR_ACK` goes to `S_TX` for a read and to `S_CMD` for a write.
  - `S_CMD_ACK` goes to `S_CNT` in block mode and to `S_WDATA` in indexed mode.
  - `S_CNT_ACK` and `S_WDATA_ACK` go to `S_WDATA`.
- `S_TX` moves to `S_HOST_ACK` on the eighth falling clock.
- `S_HOST_ACK` returns to `S_TX` after a host acknowledge and goes to `S_WAIT` after a not-acknowledge.

Top module: `smb_cfg_slave`

## Requirements
- R1: Only the address bytes 0xDC (write) and 0xDD (read) are acknowledged. Any other address gets no acknowledge, the data line is left released, and no register changes for the rest of that frame.
- R2: The slave pulls the data line low through the whole ninth clock after a matching address byte, after every command byte, after a block count byte, and after every accepted write data byte. It only starts to drive the line while the serial clock is low.
- R3: A command byte with bit 7 = 1 writes the next data byte to the register indexed by bits 6:0. Any further data byte in that frame gets no acknowledge and is ignored.
- R4: A read that follows an indexed command returns the indexed register, most significant bit first. Each host acknowledge moves the read on to the next index.
- R5: A command byte with bit 7 = 0 starts a block write at register 0. The next byte is a count, which is clamped to NUM_REGS. The following count data bytes go to ascending registers. Data bytes beyond the count get no acknowledge and are ignored.
- R6: When a block write is stopped early, the registers already sent keep their new values and the rest keep their old values.
- R7: A read that follows a block command first returns NUM_REGS as the count byte. It then returns registers 0 upward, and a host not-acknowledge ends the read and releases the line.
- R8: A write to an index at or above NUM_REGS is acknowledged but changes nothing, and a read of such an index returns 0xFF.
- R9: Reset loads every register with its byte from the DEFAULTS parameter (register i from bits 8i+7:8i) and releases the data line.
- R10: A start condition at any point, even in the middle of a byte, restarts address reception. A stop condition at any point returns the slave to idle with the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Resolved level of the open-drain data line |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| reg_bank | output | NUM_REGS*8 | Flat register bank, register i in bits 8i+7:8i |

## Verification
The bench sweeps every index for both indexed writes and indexed reads, and it sweeps block write counts from 0 through NUM_REGS and beyond. A design that did not clamp the count would acknowledge and store past the last register. A design that mishandled a zero count would accept data bytes that should be refused. The bench also sends a second data byte in indexed mode, which a design that keeps writing would store. It stops a block write part-way, which a design that buffers the data would lose. It reads past the last register, which a design that wraps the index would answer with register 0 and not 0xFF. Finally, it breaks a byte with a repeated start and with a stop. A design that kept its bit count across either would misframe the next address, and the next indexed write would then fail or go to the wrong register.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_CNT,
        S_CNT_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_HOST_ACK,
        S_WAIT
    } smb_state_e;

    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;
    logic       scl_p;
    logic       sda_p;

    // Two flops for metastability, a third to hold the previous level.
    // The bus is idle high, so reset loads ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[1];
    assign sda_s = sda_pipe[1];
    assign scl_p = scl_pipe[2];
    assign sda_p = sda_pipe[2];

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [smb_pkg::IDX_W-1:0]      wr_idx,
    input  logic [7:0]                     wr_data,
    input  logic [smb_pkg::IDX_W-1:0]      rd_idx,
    output logic [7:0]                     rd_data,
    output logic [NUM_REGS*8-1:0]          bank_q
);

    localparam int IW = smb_pkg::IDX_W;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_q[g*8 +: 8] <= DEFAULTS[g*8 +: 8];
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    bank_q[g*8 +: 8] <= wr_data;
                end
            end
        end
    endgenerate

    // Indices with no register behind them read as all ones.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = bank_q[i*8 +: 8];
            end
        end
    end

    // R8: a write past the last register leaves the bank untouched
    p_oob_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= IW'(NUM_REGS))) |=> $stable(bank_q));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter int                    NUM_REGS = 8,
    parameter logic [7:0]            DEV_ADDR = 8'hDC,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'h0F1E_2D3C_4B5A_6978
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_bank
);

    import smb_pkg::*;

    localparam int         IW      = IDX_W;
    localparam logic [7:0] N_REGS8 = 8'(NUM_REGS);
    localparam logic [7:0] RD_ADDR = DEV_ADDR | 8'h01;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smb_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_state_e     state, nstate;
    logic [3:0]     bit_cnt;
    logic [7:0]     sh;
    logic [7:0]     tx_sr;
    logic           ack_q;
    logic           drv;
    logic           hnack;
    logic           rw_q;
    logic           mode_blk;
    logic           byte_done;
    logic [IW-1:0]  ptr;
    logic [7:0]     cnt_left;
    logic           wr_en;
    logic [IW-1:0]  wr_idx;
    logic [7:0]     wr_data;
    logic [7:0]     rd_data;

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .bank_q  (reg_bank)
    );

    logic       rx_state, ack_state, byte_end, ack_exit, accept;
    logic [7:0] in_byte;

    assign rx_state  = (state == S_ADDR) || (state == S_CMD) ||
                       (state == S_CNT)  || (state == S_WDATA);
    assign ack_state = (state == S_ADDR_ACK) || (state == S_CMD_ACK) ||
                       (state == S_CNT_ACK)  || (state == S_WDATA_ACK);
    assign in_byte   = {sh[6:0], sda_s};
    assign byte_end  = rx_state && scl_rise && (bit_cnt == 4'd7);
    assign ack_exit  = scl_fall && drv;
    assign accept    = mode_blk ? (cnt_left != 8'd0) : !byte_done;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // ---------------- transitions ----------------
    always_comb begin
        nstate = state;
        if (stop_ev) begin
            nstate = S_IDLE;
        end else if (start_ev) begin
            nstate = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE, S_WAIT: nstate = state;
                S_ADDR:  if (byte_end) nstate = S_ADDR_ACK;
                S_CMD:   if (byte_end) nstate = S_CMD_ACK;
                S_CNT:   if (byte_end) nstate = S_CNT_ACK;
                S_WDATA: if (byte_end) nstate = S_WDATA_ACK;
                S_ADDR_ACK:
                    if (ack_exit) nstate = !ack_q ? S_WAIT : (rw_q ? S_TX : S_CMD);
                S_CMD_ACK:
                    if (ack_exit) nstate = mode_blk ? S_CNT : S_WDATA;
                S_CNT_ACK:
                    if (ack_exit) nstate = S_WDATA;
                S_WDATA_ACK:
                    if (ack_exit) nstate = ack_q ? S_WDATA : S_WAIT;
                S_TX:
                    if (scl_fall && (bit_cnt == 4'd8)) nstate = S_HOST_ACK;
                S_HOST_ACK:
                    if (ack_exit) nstate = hnack ? S_WAIT : S_TX;
                default: nstate = S_IDLE;
            endcase
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            sh        <= '0;
            tx_sr     <= 8'hFF;
            ack_q     <= 1'b0;
            drv       <= 1'b0;
            hnack     <= 1'b0;
            rw_q      <= 1'b0;
            mode_blk  <= 1'b0;
            byte_done <= 1'b0;
            ptr       <= '0;
            cnt_left  <= '0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev || stop_ev) begin
                bit_cnt <= '0;
                drv     <= 1'b0;
            end else begin
                if (rx_state && scl_rise) begin
                    sh      <= in_byte;
                    bit_cnt <= (bit_cnt == 4'd7) ? 4'd0 : bit_cnt + 4'd1;
                end
                if (byte_end) begin
                    if (state == S_ADDR) begin
                        ack_q <= (in_byte == DEV_ADDR) || (in_byte == RD_ADDR);
                        rw_q  <= in_byte[0];
                    end else if (state == S_CMD) begin
                        ack_q     <= 1'b1;
                        mode_blk  <= !in_byte[7];
                        ptr       <= in_byte[7] ? in_byte[6:0] : '0;
                        byte_done <= 1'b0;
                        cnt_left  <= '0;
                    end else if (state == S_CNT) begin
                        ack_q    <= 1'b1;
                        cnt_left <= (in_byte > N_REGS8) ? N_REGS8 : in_byte;
                    end else begin
                        ack_q <= accept;
                        if (accept) begin
                            wr_en     <= 1'b1;
                            wr_idx    <= ptr;
                            wr_data   <= in_byte;
                            ptr       <= ptr + 1'b1;
                            byte_done <= 1'b1;
                            if (mode_blk) cnt_left <= cnt_left - 8'd1;
                        end
                    end
                end
                if (ack_state && scl_fall) begin
                    drv <= !drv;
                    if (drv && (state == S_ADDR_ACK) && ack_q && rw_q) begin
                        bit_cnt <= '0;
                        if (mode_blk) begin
                            tx_sr <= N_REGS8;
                            ptr   <= '0;
                        end else begin
                            tx_sr <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                end
                if (state == S_TX) begin
                    if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) bit_cnt <= '0;
                        else                 tx_sr   <= {tx_sr[6:0], 1'b1};
                    end
                end
                if (state == S_HOST_ACK) begin
                    if (scl_rise) begin
                        hnack <= sda_s;
                        drv   <= 1'b1;
                    end
                    if (ack_exit) begin
                        drv <= 1'b0;
                        if (!hnack) begin
                            tx_sr <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_CMD_ACK, S_CNT_ACK, S_WDATA_ACK: sda_oe = ack_q && drv;
            S_TX:                                          sda_oe = !tx_sr[7];
            default:                                       sda_oe = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    // R2: the line is only taken low while the serial clock is low
    p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R10: a stop always lands in idle
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == S_IDLE));

    // R10: a start always restarts address reception at bit zero
    p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> ((state == S_ADDR) && (bit_cnt == 4'd0)));

    // R5: the remaining block count never exceeds the bank size
    p_count_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_left <= N_REGS8);

    // R3: a second indexed data byte never reaches the bank
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && (state == S_WDATA) && !mode_blk && byte_done) |=> !wr_en);

    // R1: an unmatched address never pulls the line
    p_nomatch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ADDR_ACK) && !ack_q) |-> !sda_oe);

endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

    localparam int             N   = 8;
    localparam logic [7:0]     DEV = 8'hDC;
    localparam logic [N*8-1:0] DEF = 64'hA1B2_C3D4_E5F6_0718;
    localparam int             Q   = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_h = 1'b1;
    logic         sda_h = 1'b1;
    logic         sda_oe;
    logic         sda_line;
    logic [N*8-1:0] bank;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [N];

    always #2 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smb_cfg_slave #(
        .NUM_REGS (N),
        .DEV_ADDR (DEV),
        .DEFAULTS (DEF)
    ) i_smb_cfg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_bank (bank)
    );

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < N; i++) mdl[i] = DEF[i*8 +: 8];
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < N; i++) chk(req, 32'(bank[i*8 +: 8]), 32'(mdl[i]));
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;    tick(Q);
        scl_h = 1'b1; tick(2*Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        acked = (x == 1'b0);
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(!host_ack);
        sda_h = 1'b1;
    endtask

    task automatic byte_write(input logic [6:0] idx, input logic [7:0] val, input string req);
        logic a;
        bus_start();
        send_byte(DEV, a);                 chk({req, " addr ack R2"}, 32'(a), 32'd1);
        send_byte({1'b1, idx}, a);         chk({req, " cmd ack R2"}, 32'(a), 32'd1);
        send_byte(val, a);                 chk({req, " data ack R2"}, 32'(a), 32'd1);
        bus_stop();
        if (idx < N) mdl[idx] = val;
    endtask

    task automatic byte_read(input logic [6:0] idx, output logic [7:0] val);
        logic a;
        bus_start();
        send_byte(DEV, a);
        send_byte({1'b1, idx}, a);
        bus_start();
        send_byte(DEV | 8'h01, a);         chk("R1 read addr ack", 32'(a), 32'd1);
        recv_byte(1'b0, val);
        bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] v;
        logic [7:0] exp_v;
        int         lim;

        mdl_reset();
        tick(5);
        chk("R9 reset release", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        tick(5);
        chk_bank("R9 defaults");

        // R1: foreign addresses get no acknowledge and no write
        begin
            logic [7:0] bad [5] = '{8'hDE, 8'h5C, 8'hDA, 8'h00, 8'h9C};
            for (int k = 0; k < 5; k++) begin
                bus_start();
                send_byte(bad[k], a);      chk("R1 foreign addr nack", 32'(a), 32'd0);
                send_byte(8'h81, a);       chk("R1 no cmd ack", 32'(a), 32'd0);
                send_byte(8'h00, a);
                chk("R1 line released", 32'(sda_oe), 32'd0);
                bus_stop();
            end
            chk_bank("R1 bank unchanged");
        end

        // R3: indexed writes to every register
        for (int i = 0; i < N; i++) begin
            byte_write(7'(i), 8'(i * 37 + 11), "R3");
        end
        chk_bank("R3 indexed sweep");

        // R4: indexed reads of every register
        for (int i = 0; i < N; i++) begin
            byte_read(7'(i), v);
            chk("R4 indexed read", 32'(v), 32'(mdl[i]));
        end

        // R4: host acknowledge continues to the next index
        bus_start();
        send_byte(DEV, a);
        send_byte(8'h85, a);
        bus_start();
        send_byte(DEV | 8'h01, a);
        recv_byte(1'b1, v);               chk("R4 first of run", 32'(v), 32'(mdl[5]));
        recv_byte(1'b0, v);               chk("R4 next index", 32'(v), 32'(mdl[6]));
        bus_stop();

        // R3: second data byte in indexed mode refused
        bus_start();
        send_byte(DEV, a);
        send_byte(8'h82, a);
        send_byte(8'h3E, a);              chk("R3 first data ack", 32'(a), 32'd1);
        send_byte(8'hC1, a);              chk("R3 second data nack", 32'(a), 32'd0);
        bus_stop();
        mdl[2] = 8'h3E;
        chk_bank("R3 second byte ignored");

        // R8: out-of-range index
        byte_write(7'h45, 8'h00, "R8");
        chk_bank("R8 oob write no effect");
        byte_read(7'h45, v);
        chk("R8 oob read", 32'(v), 32'hFF);

        // R5: block write counts 0..N and beyond
        for (int c = 0; c <= N + 3; c++) begin
            lim = (c > N) ? N : c;
            bus_start();
            send_byte(DEV, a);
            send_byte(8'h00, a);          chk("R5 block cmd ack", 32'(a), 32'd1);
            send_byte(8'(c), a);          chk("R5 count ack", 32'(a), 32'd1);
            for (int k = 0; k < lim + 1; k++) begin
                exp_v = 8'(c * 16 + k * 5 + 3);
                send_byte(exp_v, a);
                chk("R5 data ack", 32'(a), (k < lim) ? 32'd1 : 32'd0);
                if (k < lim) mdl[k] = exp_v;
                if (a == 1'b0) break;
            end
            bus_stop();
            chk_bank("R5 block write");
        end

        // R6: early stop
        bus_start();
        send_byte(DEV, a);
        send_byte(8'h00, a);
        send_byte(8'd8, a);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'(8'hC0 + k), a);
            mdl[k] = 8'(8'hC0 + k);
        end
        bus_stop();
        chk_bank("R6 early stop");

        // R7: block read, one past the end, then host nack
        bus_start();
        send_byte(DEV, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(DEV | 8'h01, a);        chk("R7 read addr ack", 32'(a), 32'd1);
        recv_byte(1'b1, v);               chk("R7 count byte", 32'(v), 32'(N));
        for (int k = 0; k < N; k++) begin
            recv_byte(1'b1, v);
            chk("R7 block data", 32'(v), 32'(mdl[k]));
        end
        recv_byte(1'b0, v);               chk("R7 past end", 32'(v), 32'hFF);
        tick(Q);
        chk("R7 released after nack", 32'(sda_oe), 32'd0);
        bus_stop();

        // R10: repeated start mid-byte, then a clean write
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(DEV, a);                chk("R10 addr after restart", 32'(a), 32'd1);
        send_byte(8'h85, a);
        send_byte(8'h77, a);              chk("R10 data after restart", 32'(a), 32'd1);
        bus_stop();
        mdl[5] = 8'h77;
        chk_bank("R10 restart write");

        // R10: stop mid-byte
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        chk("R10 idle after stop", 32'(sda_oe), 32'd0);
        byte_write(7'd1, 8'h5D, "R10");
        chk_bank("R10 write after stop");

        // R9: reset restores defaults
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        mdl_reset();
        chk_bank("R9 reset again");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule